// File: doc/BRIEF.md
# Sixteen-bit ALU with overflow word

This block is the arithmetic and logic stage of a small 16-bit processor. It takes an opcode and two operands, computes the value that goes back to the destination operand, and produces a full-width overflow word. The overflow word replaces the usual carry flag. Each arithmetic operation defines this word exactly: carry, borrow, the high half of a product, a binary fraction of a quotient, or the bits shifted out of a word. The logical operations leave the stored overflow word alone. Operand fetch, the conditional-skip opcodes and write-back lie outside this block. The block only says what to write and whether to write it.

A caller pulses `start` with the opcode and operands. Set, add, subtract, the shifts and the bitwise operations finish in one cycle. Multiply runs as a shift-and-add over W steps. Divide and remainder run as one long division over 2W steps, which yields the quotient, the remainder and the fractional overflow word together. While an operation runs, the block ignores any further `start`. When the operation ends, `done` pulses for one cycle, and the two write enables are valid in that cycle. The result and overflow outputs then stay unchanged until the next accepted operation completes.

Top module: `ovf_alu`

## Requirements
- R1: Opcode 0x1 returns b. Opcodes 0x9, 0xa and 0xb return a AND b, a OR b and a XOR b. All four assert res_we, hold ovf_we low and present ovf_val as zero.
- R2: Opcode 0x2 returns (a+b) mod 2^W. ovf_val is 1 when the unsigned sum carries out and 0 otherwise. ovf_we is high.
- R3: Opcode 0x3 returns (a-b) mod 2^W. ovf_val is all ones when b > a and 0 otherwise. ovf_we is high.
- R4: Opcode 0x4 returns the low W bits of a*b. ovf_val carries bits 2W-1..W of the product. ovf_we is high.
- R5: Opcode 0x5 returns floor(a/b), and ovf_val is floor(a*2^W/b) mod 2^W. When b is 0, both are 0. ovf_we is high.
- R6: Opcode 0x6 returns a mod b, or 0 when b is 0. ovf_we is low and ovf_val reads zero.
- R7: Opcode 0x7 forms the 2W-bit value a shifted left by b. result is its low W bits and ovf_val its high W bits.
- R8: Opcode 0x8 forms a*2^W shifted right by b as a 2W-bit value. result is its high W bits and ovf_val its low W bits.
- R9: For opcodes 0x7 and 0x8, a shift amount b of 2W or more gives 0 for both result and ovf_val.
- R10: Opcodes 0x0 and 0xc to 0xf complete with a done pulse. Both write enables stay low, and result and ovf_val keep their previous values.
- R11: Each accepted start produces exactly one one-cycle done pulse. res_we and ovf_we are high only in that cycle. A start that arrives while an operation is running is ignored.
- R12: Reset clears result, ovf_val, done and both write enables to zero. Between done pulses, result and ovf_val do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| opcode | input | 4 | Operation select |
| opa | input | W (16) | Operand a (destination value) |
| opb | input | W (16) | Operand b |
| result | output | W (16) | Value for operand a |
| ovf_val | output | W (16) | New overflow word |
| ovf_we | output | 1 | Overflow word write enable, valid with done |
| res_we | output | 1 | Result write enable, valid with done |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with the default W of 16. At that width the multiplier runs its full 16 steps and the divider its full 32, so the ignored-start case lands while the divider is still running. The shift cutoff of 32 can be reached with an ordinary operand, so amounts of 31, 32 and 0xffff sit on both sides of it. At this width the products, quotients and fractions can also be checked against exact 64-bit arithmetic in the bench, including the all-ones multiply and the divide and remainder by zero.

// File: rtl/ovf_alu_pkg.sv
package ovf_alu_pkg;

    localparam logic [3:0] OPC_SET = 4'h1;
    localparam logic [3:0] OPC_ADD = 4'h2;
    localparam logic [3:0] OPC_SUB = 4'h3;
    localparam logic [3:0] OPC_MUL = 4'h4;
    localparam logic [3:0] OPC_DIV = 4'h5;
    localparam logic [3:0] OPC_MOD = 4'h6;
    localparam logic [3:0] OPC_SHL = 4'h7;
    localparam logic [3:0] OPC_SHR = 4'h8;
    localparam logic [3:0] OPC_AND = 4'h9;
    localparam logic [3:0] OPC_BOR = 4'ha;
    localparam logic [3:0] OPC_XOR = 4'hb;

    // Which execution unit serves an opcode
    typedef enum logic [1:0] {
        CLS_NONE,
        CLS_COMB,
        CLS_MUL,
        CLS_DIV
    } op_cls_e;

    typedef struct packed {
        op_cls_e cls;
        logic    res_we;
        logic    o_we;
    } op_ctl_t;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } alu_st_e;

    function automatic op_ctl_t decode_op(input logic [3:0] opc);
        op_ctl_t c;
        c.cls    = CLS_NONE;
        c.res_we = 1'b0;
        c.o_we   = 1'b0;
        case (opc)
            OPC_SET, OPC_AND, OPC_BOR, OPC_XOR: begin
                c.cls = CLS_COMB; c.res_we = 1'b1;
            end
            OPC_ADD, OPC_SUB, OPC_SHL, OPC_SHR: begin
                c.cls = CLS_COMB; c.res_we = 1'b1; c.o_we = 1'b1;
            end
            OPC_MUL: begin
                c.cls = CLS_MUL; c.res_we = 1'b1; c.o_we = 1'b1;
            end
            OPC_DIV: begin
                c.cls = CLS_DIV; c.res_we = 1'b1; c.o_we = 1'b1;
            end
            OPC_MOD: begin
                c.cls = CLS_DIV; c.res_we = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ovf_alu_comb.sv
module ovf_alu_comb
    import ovf_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   opc,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic [W-1:0] ov
);
    localparam int         AW    = $clog2(2 * W);
    localparam logic [W:0] SHLIM = (W + 1)'(2 * W);

    logic [W:0]     sum;
    logic [W:0]     dif;
    logic [2*W-1:0] wl;
    logic [2*W-1:0] wr;
    logic [AW-1:0]  amt;
    logic           big;

    assign sum = {1'b0, a} + {1'b0, b};
    assign dif = {1'b0, a} - {1'b0, b};
    assign big = ({1'b0, b} >= SHLIM);
    assign amt = b[AW-1:0];
    assign wl  = {{W{1'b0}}, a} << amt;
    assign wr  = {a, {W{1'b0}}} >> amt;

    always_comb begin
        res = '0;
        ov  = '0;
        case (opc)
            OPC_SET: res = b;
            OPC_ADD: begin
                res = sum[W-1:0];
                ov  = {{(W-1){1'b0}}, sum[W]};
            end
            OPC_SUB: begin
                res = dif[W-1:0];
                ov  = {W{dif[W]}};
            end
            OPC_SHL: begin
                if (!big) begin
                    res = wl[W-1:0];
                    ov  = wl[2*W-1:W];
                end
            end
            OPC_SHR: begin
                if (!big) begin
                    res = wr[2*W-1:W];
                    ov  = wr[W-1:0];
                end
            end
            OPC_AND: res = a & b;
            OPC_BOR: res = a | b;
            OPC_XOR: res = a ^ b;
            default: ;
        endcase
    end

endmodule

// File: rtl/ovf_alu_mul.sv
module ovf_alu_mul #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           fin,
    output logic [2*W-1:0] prod
);
    localparam int CW = $clog2(W) + 1;

    logic [2*W-1:0] mcand;
    logic [W-1:0]   mplier;
    logic [CW-1:0]  cnt;
    logic           run;

    always_ff @(posedge clk) begin
        if (rst) begin
            prod   <= '0;
            mcand  <= '0;
            mplier <= '0;
            cnt    <= '0;
            run    <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                prod   <= '0;
                mcand  <= {{W{1'b0}}, a};
                mplier <= b;
                cnt    <= '0;
                run    <= 1'b1;
            end else if (run) begin
                if (mplier[0]) prod <= prod + mcand;
                mcand  <= mcand << 1;
                mplier <= mplier >> 1;
                cnt    <= cnt + 1'b1;
                if (cnt == CW'(W - 1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end

    // R4: a running multiply either continues or completes
    p_mul_progress_r4: assert property (@(posedge clk) disable iff (rst)
        run |=> (run || fin));
    p_mul_fin_idle_r4: assert property (@(posedge clk) disable iff (rst)
        fin |-> !run);

endmodule

// File: rtl/ovf_alu_div.sv
module ovf_alu_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         fin,
    output logic [W-1:0] quot,
    output logic [W-1:0] frac,
    output logic [W-1:0] modr
);
    localparam int CW = $clog2(2 * W) + 1;

    logic [W-1:0]   rem;
    logic [W-1:0]   b_q;
    logic [2*W-1:0] dvd;
    logic [2*W-1:0] quo;
    logic [CW-1:0]  cnt;
    logic           run;
    logic [W:0]     trial;
    logic [W:0]     rnext;
    logic           ge;

    // One restoring step on the dividend a*2^W
    assign trial = {rem, dvd[2*W-1]};
    assign ge    = (trial >= {1'b0, b_q});
    assign rnext = ge ? (trial - {1'b0, b_q}) : trial;
    assign quot  = quo[2*W-1:W];
    assign frac  = quo[W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rem  <= '0;
            b_q  <= '0;
            dvd  <= '0;
            quo  <= '0;
            modr <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                rem <= '0;
                b_q <= b;
                dvd <= {a, {W{1'b0}}};
                quo <= '0;
                cnt <= '0;
                run <= 1'b1;
            end else if (run) begin
                rem <= rnext[W-1:0];
                dvd <= dvd << 1;
                quo <= {quo[2*W-2:0], ge};
                cnt <= cnt + 1'b1;
                if (cnt == CW'(W - 1)) modr <= rnext[W-1:0];
                if (cnt == CW'(2 * W - 1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end

    // R5: a running division either continues or completes
    p_div_progress_r5: assert property (@(posedge clk) disable iff (rst)
        run |=> (run || fin));
    p_div_fin_idle_r5: assert property (@(posedge clk) disable iff (rst)
        fin |-> !run);

endmodule

// File: rtl/ovf_alu.sv
module ovf_alu
    import ovf_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [3:0]   opcode,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] result,
    output logic [W-1:0] ovf_val,
    output logic         ovf_we,
    output logic         res_we,
    output logic         done
);
    localparam logic [W:0] SHLIM = (W + 1)'(2 * W);

    alu_st_e        st;
    op_ctl_t        ctl;
    op_ctl_t        ctl_q;
    logic [3:0]     op_q;
    logic [W-1:0]   b_q;
    logic           accept;
    logic           mul_go;
    logic           div_go;
    logic           mul_fin;
    logic           div_fin;
    logic [W-1:0]   c_res;
    logic [W-1:0]   c_ov;
    logic [2*W-1:0] prod;
    logic [W-1:0]   quot;
    logic [W-1:0]   frac;
    logic [W-1:0]   modr;

    assign ctl    = decode_op(opcode);
    assign accept = start && (st == ST_IDLE);
    assign mul_go = accept && (ctl.cls == CLS_MUL);
    assign div_go = accept && (ctl.cls == CLS_DIV);

    ovf_alu_comb #(.W(W)) u_comb (
        .opc (opcode),
        .a   (opa),
        .b   (opb),
        .res (c_res),
        .ov  (c_ov)
    );

    ovf_alu_mul #(.W(W)) u_mul (
        .clk  (clk),
        .rst  (rst),
        .go   (mul_go),
        .a    (opa),
        .b    (opb),
        .fin  (mul_fin),
        .prod (prod)
    );

    ovf_alu_div #(.W(W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .go   (div_go),
        .a    (opa),
        .b    (opb),
        .fin  (div_fin),
        .quot (quot),
        .frac (frac),
        .modr (modr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ctl_q   <= '0;
            op_q    <= '0;
            b_q     <= '0;
            result  <= '0;
            ovf_val <= '0;
            ovf_we  <= 1'b0;
            res_we  <= 1'b0;
            done    <= 1'b0;
        end else begin
            done   <= 1'b0;
            ovf_we <= 1'b0;
            res_we <= 1'b0;
            if (accept) begin
                ctl_q <= ctl;
                op_q  <= opcode;
                b_q   <= opb;
                case (ctl.cls)
                    CLS_COMB: begin
                        result  <= c_res;
                        ovf_val <= c_ov;
                        res_we  <= ctl.res_we;
                        ovf_we  <= ctl.o_we;
                        done    <= 1'b1;
                    end
                    CLS_MUL, CLS_DIV: st <= ST_WAIT;
                    default: done <= 1'b1;
                endcase
            end else if (st == ST_WAIT && (mul_fin || div_fin)) begin
                st     <= ST_IDLE;
                done   <= 1'b1;
                res_we <= ctl_q.res_we;
                ovf_we <= ctl_q.o_we;
                if (ctl_q.cls == CLS_MUL) begin
                    result  <= prod[W-1:0];
                    ovf_val <= prod[2*W-1:W];
                end else if (b_q == '0) begin
                    result  <= '0;
                    ovf_val <= '0;
                end else if (op_q == OPC_DIV) begin
                    result  <= quot;
                    ovf_val <= frac;
                end else begin
                    result  <= modr;
                    ovf_val <= '0;
                end
            end
        end
    end

    // R11: write enables only accompany the done pulse
    p_we_in_done_r11: assert property (@(posedge clk) disable iff (rst)
        (ovf_we || res_we) |-> done);
    // R11: done only follows an accepted start or the end of a wait
    p_done_cause_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(accept) || ($past(st == ST_WAIT) && st == ST_IDLE)));
    // R12: outputs hold between completions
    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(result) && $stable(ovf_val)));
    // R2: add overflow word is only ever 0 or 1
    p_add_ovf_r2: assert property (@(posedge clk) disable iff (rst)
        (done && op_q == OPC_ADD) |-> (ovf_val <= W'(1)));
    // R3: subtract overflow word is all zeros or all ones
    p_sub_ovf_r3: assert property (@(posedge clk) disable iff (rst)
        (done && op_q == OPC_SUB) |-> (ovf_val == '0 || ovf_val == '1));
    // R5: divide by zero clears both outputs
    p_div_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (done && op_q == OPC_DIV && b_q == '0) |-> (result == '0 && ovf_val == '0));
    // R9: oversized shift amounts clear both outputs
    p_big_shift_r9: assert property (@(posedge clk) disable iff (rst)
        (done && (op_q == OPC_SHL || op_q == OPC_SHR) && {1'b0, b_q} >= SHLIM)
        |-> (result == '0 && ovf_val == '0));

endmodule

// File: tb/ovf_alu_tb.sv
`timescale 1ns/1ps
module ovf_alu_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [3:0]   opcode = '0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W-1:0] result;
    logic [W-1:0] ovf_val;
    logic         ovf_we;
    logic         res_we;
    logic         done;

    int checks = 0;
    int errors = 0;
    logic [15:0] last_r = '0;
    logic [15:0] last_o = '0;

    always #10 clk = ~clk;

    ovf_alu #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .opa(opa), .opb(opb), .result(result), .ovf_val(ovf_val),
        .ovf_we(ovf_we), .res_we(res_we), .done(done)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Reference model written from the requirements
    task automatic model(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                         output logic [15:0] r, output logic [15:0] o,
                         output logic rw, output logic ow);
        logic [63:0] a64, b64, w;
        a64 = {48'b0, a};
        b64 = {48'b0, b};
        r = '0; o = '0; rw = 1'b1; ow = 1'b0;
        case (op)
            4'h1: r = b;
            4'h2: begin w = a64 + b64; r = w[15:0]; o = {15'b0, w[16]}; ow = 1'b1; end
            4'h3: begin r = a - b; o = (b > a) ? 16'hffff : 16'h0; ow = 1'b1; end
            4'h4: begin w = a64 * b64; r = w[15:0]; o = w[31:16]; ow = 1'b1; end
            4'h5: begin
                ow = 1'b1;
                if (b != 0) begin
                    w = a64 / b64; r = w[15:0];
                    w = (a64 << 16) / b64; o = w[15:0];
                end
            end
            4'h6: if (b != 0) begin w = a64 % b64; r = w[15:0]; end
            4'h7: begin
                ow = 1'b1;
                if (b < 32) begin w = a64 << b; r = w[15:0]; o = w[31:16]; end
            end
            4'h8: begin
                ow = 1'b1;
                if (b < 32) begin w = (a64 << 16) >> b; r = w[31:16]; o = w[15:0]; end
            end
            4'h9: r = a & b;
            4'ha: r = a | b;
            4'hb: r = a ^ b;
            default: begin rw = 1'b0; r = last_r; o = last_o; end
        endcase
    endtask

    task automatic exec(input string tag, input logic [3:0] op,
                        input logic [15:0] a, input logic [15:0] b);
        logic [15:0] er, eo;
        logic erw, eow;
        int cyc;
        int extra;
        model(op, a, b, er, eo, erw, eow);
        @(negedge clk);
        start = 1'b1; opcode = op; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        chk(tag, "done", {31'b0, done}, 32'd1);
        chk(tag, "result", {16'b0, result}, {16'b0, er});
        chk(tag, "ovf_val", {16'b0, ovf_val}, {16'b0, eo});
        chk(tag, "res_we", {31'b0, res_we}, {31'b0, erw});
        chk(tag, "ovf_we", {31'b0, ovf_we}, {31'b0, eow});
        extra = 0;
        repeat (3) begin
            @(negedge clk);
            if (done || res_we || ovf_we) extra++;
        end
        chk({tag, " R11"}, "pulses after done", extra, 0);
        chk({tag, " R12"}, "held result", {16'b0, result}, {16'b0, er});
        chk({tag, " R12"}, "held ovf_val", {16'b0, ovf_val}, {16'b0, eo});
        last_r = er;
        last_o = eo;
    endtask

    task automatic t_reset;
        chk("R12 reset", "result", {16'b0, result}, 32'd0);
        chk("R12 reset", "ovf_val", {16'b0, ovf_val}, 32'd0);
        chk("R12 reset", "flags", {29'b0, done, res_we, ovf_we}, 32'd0);
    endtask

    task automatic t_logic;
        exec("R1 set", 4'h1, 16'h0bad, 16'h1234);
        exec("R1 and", 4'h9, 16'hf0f0, 16'h3c3c);
        exec("R1 bor", 4'ha, 16'hf000, 16'h000f);
        exec("R1 xor", 4'hb, 16'hffff, 16'h5a5a);
    endtask

    task automatic t_add;
        exec("R2 add plain", 4'h2, 16'h0001, 16'h0002);
        exec("R2 add carry", 4'h2, 16'hffff, 16'h0001);
        exec("R2 add msb", 4'h2, 16'h8000, 16'h8000);
    endtask

    task automatic t_sub;
        exec("R3 sub plain", 4'h3, 16'd5, 16'd3);
        exec("R3 sub borrow", 4'h3, 16'd3, 16'd5);
        exec("R3 sub equal", 4'h3, 16'h7777, 16'h7777);
    endtask

    task automatic t_mul;
        exec("R4 mul mixed", 4'h4, 16'h1234, 16'h5678);
        exec("R4 mul max", 4'h4, 16'hffff, 16'hffff);
        exec("R4 mul zero", 4'h4, 16'h0000, 16'hbeef);
    endtask

    task automatic t_div;
        exec("R5 div frac", 4'h5, 16'd100, 16'd7);
        exec("R5 div by one", 4'h5, 16'hffff, 16'd1);
        exec("R5 div small", 4'h5, 16'd1, 16'd3);
        exec("R5 div zero", 4'h5, 16'd5, 16'd0);
    endtask

    task automatic t_mod;
        exec("R6 mod", 4'h6, 16'd100, 16'd7);
        exec("R6 mod less", 4'h6, 16'd3, 16'd5);
        exec("R6 mod zero", 4'h6, 16'd7, 16'd0);
    endtask

    task automatic t_shl;
        exec("R7 shl one", 4'h7, 16'h8001, 16'd1);
        exec("R7 shl word", 4'h7, 16'h1234, 16'd16);
        exec("R7 shl max", 4'h7, 16'h0003, 16'd31);
    endtask

    task automatic t_shr;
        exec("R8 shr one", 4'h8, 16'h8001, 16'd1);
        exec("R8 shr far", 4'h8, 16'hc000, 16'd17);
        exec("R8 shr zero", 4'h8, 16'habcd, 16'd0);
    endtask

    task automatic t_bigshift;
        exec("R9 shl 32", 4'h7, 16'hffff, 16'd32);
        exec("R9 shr 32", 4'h8, 16'hffff, 16'd32);
        exec("R9 shl huge", 4'h7, 16'h0001, 16'hffff);
    endtask

    task automatic t_undef;
        exec("R1 set before undef", 4'h1, 16'h0000, 16'h4242);
        exec("R10 op0", 4'h0, 16'h1111, 16'h2222);
        exec("R10 opc", 4'hc, 16'h3333, 16'h4444);
        exec("R10 opf", 4'hf, 16'hffff, 16'hffff);
    endtask

    task automatic t_busy;
        logic [15:0] er, eo;
        logic erw, eow;
        int n;
        logic [15:0] gr, go;
        model(4'h5, 16'd1000, 16'd9, er, eo, erw, eow);
        @(negedge clk);
        start = 1'b1; opcode = 4'h5; opa = 16'd1000; opb = 16'd9;
        @(negedge clk);
        opcode = 4'h1; opa = 16'haaaa; opb = 16'h5555;
        repeat (3) @(negedge clk);
        start = 1'b0;
        n = 0; gr = '0; go = '0;
        repeat (80) begin
            @(negedge clk);
            if (done) begin n++; gr = result; go = ovf_val; end
        end
        chk("R11 busy", "done count", n, 1);
        chk("R11 busy", "result", {16'b0, gr}, {16'b0, er});
        chk("R11 busy", "ovf_val", {16'b0, go}, {16'b0, eo});
        last_r = er;
        last_o = eo;
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_logic();
        t_add();
        t_sub();
        t_mul();
        t_div();
        t_mod();
        t_shl();
        t_shr();
        t_bigshift();
        t_undef();
        t_busy();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule